// File: doc/BRIEF.md
# DRAM CAS-Before-RAS Refresh Scheduler

This block keeps the contents of an asynchronous DRAM alive. A free-running interval timer marks each point at which one row refresh falls due, about every 15.6 us, so that all 2048 rows are visited within the 32 ms retention window. Refreshes that have fallen due but have not yet been serviced are counted, and a request to the access controller stays high while that count is non-zero. When the controller grants the request, the scheduler takes over the RAS and CAS strobes and runs a CAS-before-RAS cycle. In that cycle the DRAM picks the row from its own internal counter, so the access controller must leave the address bus unused and the data bus undriven while `busy_o` is high.

If the owed count reaches its ceiling, refresh has fallen too far behind. A sticky overdue flag is then raised. The next grant runs a back-to-back burst of wake-up CBR cycles, which brings the device back to a known state. After the burst the owed count is cleared, along with the flag. A done pulse at the end of every CBR cycle tells the access controller when it may take the strobes back.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `req_o`, `busy_o`, `done_o` and `overdue_o` are 0, and `ras_n_o` and `cas_n_o` are 1.
- R2: The interval timer is free-running with period `INTERVAL_CYC`. Its first due point takes effect on the `INTERVAL_CYC`-th rising edge after reset release, so `req_o` rises on that edge if nothing is owed before it.
- R3: If `gnt_i` is sampled high while idle and `req_o` is high, `cas_n_o` goes low with `ras_n_o` still high on the next edge, and stays in that state for `T_CSR` cycles before `ras_n_o` falls.
- R4: `ras_n_o` then stays low for exactly `T_RAS` cycles. `cas_n_o` stays low for the first `T_CHR` of those cycles and is high for the rest.
- R5: After RAS rises, both strobes stay high for `T_RP` precharge cycles before any new strobe activity.
- R6: `done_o` is a one-cycle pulse in the last precharge cycle of every CBR cycle. `busy_o` is high from the first CAS-low cycle through that pulse.
- R7: Each due point adds one to the owed count, saturating at `PEND_MAX`. Each completed single (non-burst) CBR cycle subtracts one on the edge after `done_o`. `req_o` is high exactly while the count is non-zero.
- R8: `overdue_o` rises on the edge at which the owed count reaches `PEND_MAX`. It stays high until a wake-up burst completes.
- R9: A grant taken while `overdue_o` is high runs `WAKE_CYC` back-to-back CBR cycles with no idle cycle between them. On the edge after the last `done_o`, the owed count is cleared (keeping only a due point landing on that edge) and `overdue_o` returns to 0.
- R10: `gnt_i` has no effect while `req_o` is low, and it is ignored while a sequence is running.
- R11: Servicing refreshes does not disturb the timer. Due points keep landing on multiples of `INTERVAL_CYC` edges after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gnt_i | input | 1 | Grant from the access controller; sampled only while idle |
| req_o | output | 1 | Refresh request: one or more refreshes owed |
| busy_o | output | 1 | Scheduler owns RAS/CAS; address is don't-care and data bus must be released |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| done_o | output | 1 | One-cycle pulse at the end of each CBR cycle |
| overdue_o | output | 1 | Sticky flag: refresh backlog saturated, wake-up burst pending |

## Verification
Strobe results are due starting on the first edge after the edge that samples the grant. From there they follow a fixed step list of `T_CSR`, then `T_RAS`, then `T_RP` cycles per CBR cycle. The owed count is seen through `req_o` and `overdue_o`. A due point changes it on edge k·`INTERVAL_CYC`, and a completion changes it on the edge after `done_o`. The driver pushes one expected strobe/done/busy tuple per cycle into a queue when it grants. A monitor samples 1 ns after every rising edge and pops one tuple per cycle, or expects idle strobes when the queue is empty. Request and overdue checks are made 1 ns after named edge numbers that are counted from reset release.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_ACT   = 2'd2,
    SEQ_PRE   = 2'd3
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && INTERVAL_CYC > 1) |=> !tick_o); // R11
endmodule

// File: rtl/rfsh_owed_count.sv
module rfsh_owed_count #(
  parameter int PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic req_o,
  output logic overdue_o
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] MAXV = PW'(PEND_MAX);

  logic [PW-1:0] pend_q, pend_d;
  logic          ovd_q, ovd_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) begin
      pend_d = tick_i ? PW'(1) : '0;
    end else if (tick_i && !dec_i) begin
      if (pend_q != MAXV) pend_d = pend_q + 1'b1;
    end else if (dec_i && !tick_i) begin
      if (pend_q != '0) pend_d = pend_q - 1'b1;
    end
    ovd_d = clr_i ? 1'b0 : (ovd_q || (pend_d == MAXV));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovd_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovd_q  <= ovd_d;
    end
  end

  assign req_o     = (pend_q != '0);
  assign overdue_o = ovd_q;

  AST_PEND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= MAXV); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !dec_i && !clr_i) |=> req_o); // R7
  AST_OVERDUE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dec_i && !clr_i && pend_q == PW'(PEND_MAX - 1)) |=> overdue_o); // R8
  AST_OVERDUE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overdue_o && !clr_i) |=> overdue_o); // R8
  AST_BURST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !overdue_o); // R9
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
#(
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 2,
  parameter int T_RAS    = 13,
  parameter int T_RP     = 8,
  parameter int WAKE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic gnt_i,
  input  logic overdue_i,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o,
  output logic single_done_o,
  output logic burst_end_o
);
  localparam int MAXT = max_int(max_int(T_CSR, T_RAS), T_RP);
  localparam int CW   = $clog2(MAXT + 1);
  localparam int LW   = $clog2(WAKE_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [LW-1:0] left_q, left_d;
  logic          burst_q, burst_d;
  logic          phase_end;

  always_comb begin
    unique case (state_q)
      SEQ_SETUP: phase_end = (cyc_q == CW'(T_CSR - 1));
      SEQ_ACT:   phase_end = (cyc_q == CW'(T_RAS - 1));
      SEQ_PRE:   phase_end = (cyc_q == CW'(T_RP - 1));
      default:   phase_end = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cyc_d   = phase_end ? '0 : cyc_q + 1'b1;
    left_d  = left_q;
    burst_d = burst_q;
    unique case (state_q)
      SEQ_IDLE: begin
        cyc_d = '0;
        if (req_i && gnt_i) begin
          state_d = SEQ_SETUP;
          burst_d = overdue_i;
          left_d  = overdue_i ? LW'(WAKE_CYC - 1) : '0;
        end
      end
      SEQ_SETUP: if (phase_end) state_d = SEQ_ACT;
      SEQ_ACT:   if (phase_end) state_d = SEQ_PRE;
      SEQ_PRE: begin
        if (phase_end) begin
          if (left_q != '0) begin
            state_d = SEQ_SETUP;
            left_d  = left_q - 1'b1;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cyc_q   <= '0;
      left_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cyc_q   <= cyc_d;
      left_q  <= left_d;
      burst_q <= burst_d;
    end
  end

  // CAS leads RAS, then releases after the hold window while RAS is still low
  assign ras_n_o = (state_q != SEQ_ACT);
  assign cas_n_o = !((state_q == SEQ_SETUP) ||
                     ((state_q == SEQ_ACT) && (cyc_q < CW'(T_CHR))));
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = (state_q == SEQ_PRE) && phase_end;
  assign single_done_o = done_o && (left_q == '0) && !burst_q;
  assign burst_end_o   = done_o && (left_q == '0) && burst_q;

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_PRECHARGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_n_o && cas_n_o && busy_o)); // R5
  AST_NO_START_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> !busy_o); // R10
  AST_STROBES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_n_o && cas_n_o)); // R1
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int INTERVAL_CYC = 3900,
  parameter int PEND_MAX     = 8,
  parameter int WAKE_CYC     = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 13,
  parameter int T_RP         = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o,
  output logic overdue_o
);
  logic tick, single_done, burst_end;

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  rfsh_owed_count #(.PEND_MAX(PEND_MAX)) i_owed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .dec_i     (single_done),
    .clr_i     (burst_end),
    .req_o     (req_o),
    .overdue_o (overdue_o)
  );

  cbr_strobe_seq #(
    .T_CSR    (T_CSR),
    .T_CHR    (T_CHR),
    .T_RAS    (T_RAS),
    .T_RP     (T_RP),
    .WAKE_CYC (WAKE_CYC)
  ) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_o),
    .gnt_i         (gnt_i),
    .overdue_i     (overdue_o),
    .busy_o        (busy_o),
    .ras_n_o       (ras_n_o),
    .cas_n_o       (cas_n_o),
    .done_o        (done_o),
    .single_done_o (single_done),
    .burst_end_o   (burst_end)
  );

  AST_REQ_WHILE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !overdue_o) |-> req_o); // R7
endmodule

// File: tb/test_cbr_refresh_sched.sv
module test_cbr_refresh_sched;
  localparam int INTERVAL = 64;
  localparam int PMAX     = 4;
  localparam int WAKE     = 8;
  localparam int TCSR     = 2;
  localparam int TCHR     = 2;
  localparam int TRAS     = 5;
  localparam int TRP      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, busy, ras_n, cas_n, done, overdue;

  always #2 clk = ~clk; // 250 MHz

  cbr_refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .PEND_MAX(PMAX), .WAKE_CYC(WAKE),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) i_cbr_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req), .busy_o(busy),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .done_o(done), .overdue_o(overdue)
  );

  typedef struct packed { logic ras_n; logic cas_n; logic done; logic busy; } step_t;
  step_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_edge(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic push_cbr();
    for (int i = 0; i < TCSR; i++) exp_q.push_back('{1'b1, 1'b0, 1'b0, 1'b1});
    for (int i = 0; i < TRAS; i++) exp_q.push_back('{1'b0, (i >= TCHR), 1'b0, 1'b1});
    for (int i = 0; i < TRP; i++)  exp_q.push_back('{1'b1, 1'b1, (i == TRP - 1), 1'b1});
  endtask

  task automatic grant_cbr(input int n);
    @(negedge clk);
    check("R7 req before grant", req, 1);
    gnt = 1'b1;
    for (int k = 0; k < n; k++) push_cbr();
    @(negedge clk);
    gnt = 1'b0;
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  initial begin
    step_t e;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (exp_q.size() != 0) begin
          e = exp_q.pop_front();
          check("R3/R4/R5/R6 strobe step", {ras_n, cas_n, done, busy}, e);
        end else begin
          check("R10 idle strobes", {ras_n, cas_n, done, busy}, 4'b1100);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset req", req, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset ras_n", ras_n, 1);
    check("R1 reset cas_n", cas_n, 1);
    check("R1 reset done", done, 0);
    check("R1 reset overdue", overdue, 0);
    rst_n = 1'b1;

    // R10: grant with nothing owed
    wait_edge(4);
    @(negedge clk); gnt = 1'b1;
    repeat (4) @(negedge clk);
    gnt = 1'b0;
    @(posedge clk); #1;
    check("R10 grant without req busy", busy, 0);

    // R2: first due point
    wait_edge(INTERVAL - 1);
    check("R2 req before first due point", req, 0);
    wait_edge(INTERVAL);
    check("R2 req at first due point", req, 1);

    // R7: three owed, serviced one by one
    wait_edge(3 * INTERVAL + 8);
    check("R7 req with three owed", req, 1);
    check("R8 no overdue below max", overdue, 0);
    grant_cbr(1);
    check("R7 req after first service", req, 1);
    grant_cbr(1);
    check("R7 req after second service", req, 1);
    grant_cbr(1);
    check("R7 req after third service", req, 0);

    // R8: backlog saturates at four owed
    wait_edge(7 * INTERVAL - 1);
    check("R8 overdue one due point early", overdue, 0);
    check("R7 req with three owed again", req, 1);
    wait_edge(7 * INTERVAL);
    check("R8 overdue at saturation", overdue, 1);
    wait_edge(7 * INTERVAL + 3);
    check("R8 overdue sticky", overdue, 1);

    // R9: wake-up burst, back to back
    grant_cbr(WAKE);
    check("R9 overdue cleared after burst", overdue, 0);
    check("R9 owed cleared after burst", req, 0);

    // R11: timer kept its phase through service
    wait_edge(9 * INTERVAL - 1);
    check("R11 req before next due point", req, 0);
    wait_edge(9 * INTERVAL);
    check("R11 req at next due point", req, 1);

    repeat (2) @(posedge clk);
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule